// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block turns single commands into the bus cycles that a byte-wide parallel flash expects. A caller presents an operation code, a 17-bit target address, a data byte, a sector mask and the flash maker's identity code, then pulses a start input. The block performs the unlock write cycles for the operation, the final command write and, for program and erase, a status polling loop. It then reports an error flag and a result byte together with a one-cycle done pulse. The low 16 address bits leave on an address bus, and bit 16 leaves on a separate bank output.

Completion of a program or erase is found by reading the target byte until its bit 7 matches the expected value. A second read that shows bit 5 set ends the operation with an error, except for two identity codes whose parts do not use bit 5 this way. A retry limit ends an endless wait with an error. The strobe width, the settle time after an erase command, the spacing between polls and the retry limit are parameters counted in clock cycles.

Top module: `pflash_seq`

## Requirements
- R1: Opcode 1 (program) writes 0xAA to 0x05555, 0x55 to 0x02AAA and 0xA0 to 0x05555, in that order, and then writes the data byte to the target address. Each address here is the 17-bit value {bank, address bus}.
- R2: Opcode 2 (erase) writes six bytes in this order: 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, and then 0x30 to (target AND mask). When the identity code is 0xDA, the last byte is 0x10.
- R3: After the last erase write, at least ERASE_WAIT cycles pass with both strobes high before the first status read. Erase polling reads the unmasked target address and succeeds on a byte with bit 7 = 1.
- R4: Program polling reads the target address and ends without error on the first byte whose bit 7 equals bit 7 of the data. The done pulse then carries err = 0, and rd_data holds that byte.
- R5: For identity codes other than 0x40 and 0xDA, a single polled byte with bit 5 set does not end polling. The second such byte ends the operation with err = 1, after exactly two reads if neither byte matched.
- R6: For identity codes 0x40 and 0xDA, bit 5 of polled bytes is ignored.
- R7: Status reads are separated by at least POLL_GAP idle cycles. After POLL_MAX reads without a match, the operation ends with err = 1, and no further read is issued.
- R8: Opcode 3 (identity read) writes 0xAA@0x05555, 0x55@0x02AAA and 0x90@0x05555, then reads address 0x00001 and returns that byte on rd_data with err = 0.
- R9: Opcode 0 (byte read) issues exactly one read at the target address, with no write, and returns the byte on rd_data with err = 0.
- R10: During every strobe, fl_bank equals bit 16 of the address in use. fl_bank changes only while both strobes are high.
- R11: Each write or read strobe stays low for exactly STB_CYC cycles. fl_we_n and fl_oe_n are never low together. Address, bank and write data are stable while the write strobe is low. fl_dq_oe is high during write strobes and low during read strobes.
- R12: done is a single-cycle pulse, and busy drops after it. cmd_start while busy is ignored and is not queued.
- R13: After reset, both strobes are high and busy, done and fl_dq_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse, taken only while idle |
| cmd_op | input | 2 | 0 read, 1 program, 2 erase, 3 identity read |
| cmd_addr | input | 17 | Target byte address |
| cmd_data | input | 8 | Byte to program |
| cmd_mask | input | 17 | Sector mask applied to the erase address |
| cmd_mfr | input | 8 | Flash maker identity code |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Result of last operation: 1 = failed |
| rd_data | output | 8 | Byte read or last polled byte |
| fl_addr | output | 16 | Flash address bits 15..0 |
| fl_bank | output | 1 | Flash address bit 16 |
| fl_dq_out | output | 8 | Write data to flash |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read strobe, active low |
| fl_dq_in | input | 8 | Read data from flash |

## Verification
The hardest cases to reach are inside the polling loop: a read with bit 5 set followed by a second one, the same pattern under the two identity codes that must ignore it, and a flash that never finishes within POLL_MAX reads. The bench contains a flash model that returns a busy pattern, with bit 7 inverted and bit 5 optionally set, for a chosen number of reads before it returns the real byte. Each command can therefore be steered into success after N polls, failure on bit 5, or timeout. A start pulse injected mid-operation covers the ignored-start case.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_ID    = 2'd3
    } pf_op_e;

    typedef enum logic [1:0] {
        CY_IDLE, CY_SETUP, CY_STB, CY_HOLD
    } pf_cyc_e;

    typedef enum logic [2:0] {
        CT_IDLE, CT_SEQ, CT_SEQW, CT_ERW, CT_POLL, CT_POLLW, CT_GAP, CT_FIN
    } pf_ctl_e;

    typedef struct packed {
        logic [16:0] addr;
        logic [7:0]  data;
        logic        rd;
        logic        last;
    } pf_step_t;

    localparam logic [16:0] UNLOCK_HI = 17'h05555;
    localparam logic [16:0] UNLOCK_LO = 17'h02AAA;
    localparam logic [16:0] ID_LOC    = 17'h00001;
    localparam logic [7:0]  MFR_QUIET = 8'h40;
    localparam logic [7:0]  MFR_ALT   = 8'hDA;

    // Bit 5 of status reads is meaningful except for two makers.
    function automatic logic dq5_used(input logic [7:0] mfr);
        return !(mfr == MFR_QUIET || mfr == MFR_ALT);
    endfunction

    function automatic pf_step_t wr_step(input logic [16:0] a, input logic [7:0] d,
                                         input logic last);
        pf_step_t s;
        s.addr = a; s.data = d; s.rd = 1'b0; s.last = last;
        return s;
    endfunction

    // Bus cycle number idx of a command sequence.
    function automatic pf_step_t seq_step(input pf_op_e op, input logic [2:0] idx,
                                          input logic [16:0] addr, input logic [7:0] data,
                                          input logic [16:0] mask, input logic [7:0] mfr);
        pf_step_t s;
        s = wr_step(UNLOCK_HI, 8'hAA, 1'b0);
        case (op)
            OP_READ: begin
                s.addr = addr; s.data = 8'h00; s.rd = 1'b1; s.last = 1'b1;
            end
            OP_PROG, OP_ID: begin
                case (idx)
                    3'd0:    s = wr_step(UNLOCK_HI, 8'hAA, 1'b0);
                    3'd1:    s = wr_step(UNLOCK_LO, 8'h55, 1'b0);
                    3'd2:    s = wr_step(UNLOCK_HI, (op == OP_PROG) ? 8'hA0 : 8'h90, 1'b0);
                    default: begin
                        if (op == OP_PROG) s = wr_step(addr, data, 1'b1);
                        else begin
                            s.addr = ID_LOC; s.data = 8'h00; s.rd = 1'b1; s.last = 1'b1;
                        end
                    end
                endcase
            end
            default: begin
                case (idx)
                    3'd0, 3'd3: s = wr_step(UNLOCK_HI, 8'hAA, 1'b0);
                    3'd1, 3'd4: s = wr_step(UNLOCK_LO, 8'h55, 1'b0);
                    3'd2:       s = wr_step(UNLOCK_HI, 8'h80, 1'b0);
                    default:    s = wr_step(addr & mask,
                                            (mfr == MFR_ALT) ? 8'h10 : 8'h30, 1'b1);
                endcase
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pflash_cycle.sv
module pflash_cycle
    import pflash_pkg::*;
#(
    parameter int STB_CYC = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic [16:0] req_addr,
    input  logic [7:0]  req_data,
    input  logic        req_rd,
    output logic        ack,
    output logic [7:0]  ack_data,
    output logic [15:0] fl_addr,
    output logic        fl_bank,
    output logic [7:0]  fl_dq_out,
    output logic        fl_dq_oe,
    output logic        fl_we_n,
    output logic        fl_oe_n,
    input  logic [7:0]  fl_dq_in
);
    localparam int CW = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STB_CYC - 1);

    pf_cyc_e       st;
    logic [CW-1:0] cnt;
    logic [15:0]   a_q;
    logic          bank_q;
    logic [7:0]    d_q;
    logic          rd_q;
    logic [7:0]    smp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= CY_IDLE;
            cnt    <= '0;
            a_q    <= '0;
            bank_q <= 1'b0;
            d_q    <= '0;
            rd_q   <= 1'b0;
            smp_q  <= '0;
        end else begin
            case (st)
                CY_IDLE: if (req) begin
                    a_q  <= req_addr[15:0];
                    if (bank_q != req_addr[16]) bank_q <= req_addr[16];
                    d_q  <= req_data;
                    rd_q <= req_rd;
                    st   <= CY_SETUP;
                end
                CY_SETUP: begin
                    cnt <= '0;
                    st  <= CY_STB;
                end
                CY_STB: begin
                    if (cnt == CNT_LAST) begin
                        smp_q <= fl_dq_in;
                        st    <= CY_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= CY_IDLE;
            endcase
        end
    end

    assign ack       = (st == CY_HOLD);
    assign ack_data  = smp_q;
    assign fl_addr   = a_q;
    assign fl_bank   = bank_q;
    assign fl_dq_out = d_q;
    assign fl_dq_oe  = (st != CY_IDLE) && !rd_q;
    assign fl_we_n   = !((st == CY_STB) && !rd_q);
    assign fl_oe_n   = !((st == CY_STB) && rd_q);

endmodule

// File: rtl/pflash_ctrl.sv
module pflash_ctrl
    import pflash_pkg::*;
#(
    parameter int ERASE_WAIT = 7500,
    parameter int POLL_GAP   = 500,
    parameter int POLL_MAX   = 3000000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_start,
    input  logic [1:0]  cmd_op,
    input  logic [16:0] cmd_addr,
    input  logic [7:0]  cmd_data,
    input  logic [16:0] cmd_mask,
    input  logic [7:0]  cmd_mfr,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [7:0]  rd_data,
    output logic        req,
    output logic [16:0] req_addr,
    output logic [7:0]  req_data,
    output logic        req_rd,
    input  logic        ack,
    input  logic [7:0]  ack_data
);
    localparam int TMAX = (ERASE_WAIT > POLL_GAP) ? ERASE_WAIT : POLL_GAP;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PW   = $clog2(POLL_MAX + 1);
    localparam logic [TW-1:0] ERW_LAST = TW'(ERASE_WAIT - 1);
    localparam logic [TW-1:0] GAP_LAST = TW'(POLL_GAP - 1);
    localparam logic [PW-1:0] TRY_LAST = PW'(POLL_MAX - 1);

    pf_ctl_e       st;
    pf_op_e        op_q;
    logic [2:0]    idx;
    logic [16:0]   addr_q, mask_q;
    logic [7:0]    data_q, mfr_q;
    logic [TW-1:0] tmr;
    logic [PW-1:0] tries;
    logic          seen5;
    logic          err_q;
    logic [7:0]    rd_q;
    pf_step_t      step;
    logic          exp7;
    logic          chk5;

    assign step = seq_step(op_q, idx, addr_q, data_q, mask_q, mfr_q);
    assign exp7 = (op_q == OP_ERASE) ? 1'b1 : data_q[7];
    assign chk5 = dq5_used(mfr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= CT_IDLE;
            op_q   <= OP_READ;
            idx    <= '0;
            addr_q <= '0;
            mask_q <= '0;
            data_q <= '0;
            mfr_q  <= '0;
            tmr    <= '0;
            tries  <= '0;
            seen5  <= 1'b0;
            err_q  <= 1'b0;
            rd_q   <= '0;
        end else begin
            case (st)
                CT_IDLE: if (cmd_start) begin
                    op_q   <= pf_op_e'(cmd_op);
                    addr_q <= cmd_addr;
                    data_q <= cmd_data;
                    mask_q <= cmd_mask;
                    mfr_q  <= cmd_mfr;
                    idx    <= '0;
                    st     <= CT_SEQ;
                end
                CT_SEQ: st <= CT_SEQW;
                CT_SEQW: if (ack) begin
                    if (step.last) begin
                        tries <= '0;
                        seen5 <= 1'b0;
                        tmr   <= '0;
                        case (op_q)
                            OP_PROG:  st <= CT_POLL;
                            OP_ERASE: st <= CT_ERW;
                            default: begin
                                rd_q  <= ack_data;
                                err_q <= 1'b0;
                                st    <= CT_FIN;
                            end
                        endcase
                    end else begin
                        idx <= idx + 3'd1;
                        st  <= CT_SEQ;
                    end
                end
                CT_ERW: begin
                    if (tmr == ERW_LAST) begin
                        tmr <= '0;
                        st  <= CT_POLL;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                CT_POLL: st <= CT_POLLW;
                CT_POLLW: if (ack) begin
                    rd_q <= ack_data;
                    if (ack_data[7] == exp7) begin
                        err_q <= 1'b0;
                        st    <= CT_FIN;
                    end else if ((chk5 && ack_data[5] && seen5) || (tries == TRY_LAST)) begin
                        err_q <= 1'b1;
                        st    <= CT_FIN;
                    end else begin
                        tries <= tries + 1'b1;
                        seen5 <= seen5 | (chk5 & ack_data[5]);
                        tmr   <= '0;
                        st    <= CT_GAP;
                    end
                end
                CT_GAP: begin
                    if (tmr == GAP_LAST) begin
                        tmr <= '0;
                        st  <= CT_POLL;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: st <= CT_IDLE;
            endcase
        end
    end

    assign req      = (st == CT_SEQ) || (st == CT_POLL);
    assign req_addr = (st == CT_POLL) ? addr_q : step.addr;
    assign req_data = step.data;
    assign req_rd   = (st == CT_POLL) ? 1'b1 : step.rd;
    assign busy     = (st != CT_IDLE);
    assign done     = (st == CT_FIN);
    assign err      = err_q;
    assign rd_data  = rd_q;

endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
    import pflash_pkg::*;
#(
    parameter int STB_CYC    = 4,
    parameter int ERASE_WAIT = 7500,
    parameter int POLL_GAP   = 500,
    parameter int POLL_MAX   = 3000000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_start,
    input  logic [1:0]  cmd_op,
    input  logic [16:0] cmd_addr,
    input  logic [7:0]  cmd_data,
    input  logic [16:0] cmd_mask,
    input  logic [7:0]  cmd_mfr,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [7:0]  rd_data,
    output logic [15:0] fl_addr,
    output logic        fl_bank,
    output logic [7:0]  fl_dq_out,
    output logic        fl_dq_oe,
    output logic        fl_we_n,
    output logic        fl_oe_n,
    input  logic [7:0]  fl_dq_in
);
    logic        req, req_rd, ack;
    logic [16:0] req_addr;
    logic [7:0]  req_data, ack_data;

    pflash_ctrl #(
        .ERASE_WAIT(ERASE_WAIT), .POLL_GAP(POLL_GAP), .POLL_MAX(POLL_MAX)
    ) ctrl_i (
        .clk(clk), .rst(rst),
        .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_mask(cmd_mask), .cmd_mfr(cmd_mfr),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data),
        .req(req), .req_addr(req_addr), .req_data(req_data), .req_rd(req_rd),
        .ack(ack), .ack_data(ack_data)
    );

    pflash_cycle #(.STB_CYC(STB_CYC)) cyc_i (
        .clk(clk), .rst(rst),
        .req(req), .req_addr(req_addr), .req_data(req_data), .req_rd(req_rd),
        .ack(ack), .ack_data(ack_data),
        .fl_addr(fl_addr), .fl_bank(fl_bank), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
        .fl_dq_in(fl_dq_in)
    );

endmodule

// File: rtl/pflash_seq_chk.sv
module pflash_seq_chk #(
    parameter int STB_CYC = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [15:0] fl_addr,
    input logic        fl_bank,
    input logic [7:0]  fl_dq_out,
    input logic        fl_dq_oe,
    input logic        fl_we_n,
    input logic        fl_oe_n
);
    int low_run;
    logic stb_low;
    assign stb_low = !fl_we_n || !fl_oe_n;

    always_ff @(posedge clk) begin
        if (rst) low_run <= 0;
        else     low_run <= stb_low ? low_run + 1 : 0;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!fl_we_n && !fl_oe_n)); // R11

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (!stb_low && low_run != 0) |-> (low_run == STB_CYC)); // R11

    AST_WR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && $past(!fl_we_n)) |->
            ($stable(fl_addr) && $stable(fl_dq_out) && $stable(fl_bank))); // R11

    AST_DRIVE_DIR: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n |-> fl_dq_oe) and (!fl_oe_n |-> !fl_dq_oe)); // R11

    AST_BANK_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$stable(fl_bank) |-> ($past(fl_we_n) && $past(fl_oe_n) && fl_we_n && fl_oe_n)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R12

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (fl_we_n && fl_oe_n && !fl_dq_oe)); // R13

endmodule

bind pflash_seq pflash_seq_chk #(.STB_CYC(STB_CYC)) chk_i (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .fl_addr(fl_addr), .fl_bank(fl_bank), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
);

// File: tb/pflash_seq_tb.sv
module pflash_seq_tb_top;
    localparam int STB = 2;
    localparam int EW  = 20;
    localparam int PG  = 3;
    localparam int PM  = 8;
    localparam int LOGN = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_start = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [16:0] cmd_addr = '0, cmd_mask = '0;
    logic [7:0]  cmd_data = '0, cmd_mfr = '0;
    logic        busy, done, err, fl_bank, fl_dq_oe, fl_we_n, fl_oe_n;
    logic [7:0]  rd_data, fl_dq_out, fl_dq_in;
    logic [15:0] fl_addr;

    always #10 clk = ~clk;

    pflash_seq #(.STB_CYC(STB), .ERASE_WAIT(EW), .POLL_GAP(PG), .POLL_MAX(PM)) dut_i (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_mask(cmd_mask), .cmd_mfr(cmd_mfr),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data),
        .fl_addr(fl_addr), .fl_bank(fl_bank), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_dq_in(fl_dq_in)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;

    // flash model state driven by tests
    int         busy_cnt = 0;
    logic [7:0] busy_pat = '0, rd_val = '0;
    int         rd_base = 0;

    // monitor state (written only by the monitor)
    logic [24:0] wlog[LOGN];
    int          wend[LOGN];
    logic [16:0] rlog[LOGN];
    int          rstart[LOGN];
    int          rend[LOGN];
    int wn = 0, rn = 0, rd_ends = 0, bad_stb = 0, low_run = 0;
    logic we_prev = 1'b1, oe_prev = 1'b1;

    assign fl_dq_in = ((rd_ends - rd_base) < busy_cnt) ? busy_pat : rd_val;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (!fl_we_n && we_prev) begin
                wlog[wn % LOGN] <= {fl_bank, fl_addr, fl_dq_out};
                wn <= wn + 1;
            end
            if (fl_we_n && !we_prev) wend[(wn - 1) % LOGN] <= cyc;
            if (!fl_oe_n && oe_prev) begin
                rlog[rn % LOGN]   <= {fl_bank, fl_addr};
                rstart[rn % LOGN] <= cyc;
                rn <= rn + 1;
            end
            if (fl_oe_n && !oe_prev) begin
                rend[rd_ends % LOGN] <= cyc;
                rd_ends <= rd_ends + 1;
            end
            if (!fl_we_n || !fl_oe_n) low_run <= low_run + 1;
            else begin
                if (low_run != 0 && low_run != STB) bad_stb <= bad_stb + 1;
                low_run <= 0;
            end
        end
        we_prev <= fl_we_n;
        oe_prev <= fl_oe_n;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected write number i of an operation: {addr17, data}
    function automatic logic [24:0] exp_wr(input logic [1:0] op, input int i,
            input logic [16:0] a, input logic [7:0] d, input logic [16:0] m, input logic [7:0] mf);
        logic [16:0] u1 = 17'h05555, u2 = 17'h02AAA;
        if (op == 2'd2) begin
            case (i)
                0, 3: return {u1, 8'hAA};
                1, 4: return {u2, 8'h55};
                2:    return {u1, 8'h80};
                default: return {a & m, (mf == 8'hDA) ? 8'h10 : 8'h30};
            endcase
        end
        case (i)
            0: return {u1, 8'hAA};
            1: return {u2, 8'h55};
            2: return {u1, (op == 2'd1) ? 8'hA0 : 8'h90};
            default: return {a, d};
        endcase
    endfunction

    function automatic int n_wr(input logic [1:0] op);
        case (op)
            2'd0: return 0;
            2'd1: return 4;
            2'd2: return 6;
            default: return 3;
        endcase
    endfunction

    int wb, rb, r_w, r_r, r_done_len;
    logic r_err;
    logic [7:0] r_rd;

    task automatic run_op(input logic [1:0] op, input logic [16:0] a, input logic [7:0] d,
                          input logic [16:0] m, input logic [7:0] mf, input int nbusy,
                          input logic dq5, input logic [7:0] val, input bit inject);
        int t;
        logic e7;
        @(negedge clk); #1;
        e7 = (op == 2'd2) ? 1'b1 : d[7];
        busy_cnt = nbusy;
        busy_pat = {~e7, 1'b0, dq5, 5'b0};
        rd_val = val;
        rd_base = rd_ends;
        wb = wn; rb = rn;
        cmd_op = op; cmd_addr = a; cmd_data = d; cmd_mask = m; cmd_mfr = mf;
        cmd_start = 1'b1;
        @(negedge clk); #1;
        cmd_start = 1'b0;
        if (inject) begin
            repeat (3) @(negedge clk);
            #1;
            cmd_op = 2'd0; cmd_addr = 17'h1ABCD; cmd_start = 1'b1;
            @(negedge clk); #1;
            cmd_start = 1'b0;
        end
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, "R12", "done seen", done, 1);
        r_err = err; r_rd = rd_data;
        @(negedge clk);
        chk(!done && !busy, "R12", "done single pulse then idle", {done, busy}, 0);
        r_w = wn - wb; r_r = rn - rb;
    endtask

    task automatic check_writes(input logic [1:0] op, input logic [16:0] a, input logic [7:0] d,
                                input logic [16:0] m, input logic [7:0] mf, input string req);
        bit ok = (r_w == n_wr(op));
        logic [24:0] act = '0, exp = '0;
        for (int i = 0; i < n_wr(op) && ok; i++) begin
            act = wlog[(wb + i) % LOGN];
            exp = exp_wr(op, i, a, d, m, mf);
            if (act !== exp) ok = 0;
        end
        chk(ok, req, "write sequence", (r_w == n_wr(op)) ? act : r_w,
            (r_w == n_wr(op)) ? exp : n_wr(op));
    endtask

    task automatic check_reads_at(input logic [16:0] a, input int n, input string req);
        bit ok = (r_r == n);
        for (int i = 0; i < r_r && ok; i++)
            if (rlog[(rb + i) % LOGN] !== a) ok = 0;
        chk(ok, req, "read count/address", r_r, n);
    endtask

    task automatic check_poll_gap(input string req);
        int mn = 1000000;
        for (int i = 1; i < r_r; i++)
            if (rstart[(rb + i) % LOGN] - rend[(rb + i - 1) % LOGN] < mn)
                mn = rstart[(rb + i) % LOGN] - rend[(rb + i - 1) % LOGN];
        if (r_r > 1) chk(mn >= PG, req, "poll spacing", mn, PG);
    endtask

    initial begin
        logic [16:0] a, m;
        logic [7:0] d, mf, v;
        int nb;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk(fl_we_n && fl_oe_n && !busy && !done && !fl_dq_oe, "R13", "reset outputs",
            {fl_we_n, fl_oe_n, busy, done, fl_dq_oe}, 5'b11000);

        // R1 R4 R10: random programs
        for (int k = 0; k < 8; k++) begin
            a = 17'($urandom); d = 8'($urandom); nb = int'($urandom % 4);
            mf = 8'h01 + 8'(k);
            v = {d[7], 7'($urandom)};
            run_op(2'd1, a, d, 17'h1FFFF, mf, nb, 1'b0, v, 0);
            check_writes(2'd1, a, d, 17'h1FFFF, mf, "R1/R10");
            check_reads_at(a, nb + 1, "R4");
            chk(r_err == 1'b0 && r_rd == v, "R4", "program result", {r_err, r_rd}, {1'b0, v});
            check_poll_gap("R7");
        end

        // R2 R3: erases, alternate maker code included
        for (int k = 0; k < 6; k++) begin
            a = 17'($urandom); m = (k % 2) ? 17'h1F000 : 17'h1FF80;
            mf = (k % 3 == 0) ? 8'hDA : 8'($urandom);
            if (mf == 8'h40) mf = 8'h41;
            nb = int'($urandom % 3);
            v = {1'b1, 7'($urandom)};
            run_op(2'd2, a, 8'($urandom), m, mf, nb, 1'b0, v, 0);
            check_writes(2'd2, a, 8'h00, m, mf, "R2");
            check_reads_at(a, nb + 1, "R3");
            chk(rstart[rb % LOGN] - wend[(wb + 5) % LOGN] >= EW, "R3", "settle before poll",
                rstart[rb % LOGN] - wend[(wb + 5) % LOGN], EW);
            chk(r_err == 1'b0 && r_rd == v, "R3", "erase result", {r_err, r_rd}, {1'b0, v});
        end

        // R5: second bit-5 read fails
        run_op(2'd1, 17'h10020, 8'h5A, 17'h1FFFF, 8'h01, 6, 1'b1, 8'h5A, 0);
        chk(r_err == 1'b1, "R5", "bit5 twice -> error", r_err, 1);
        check_reads_at(17'h10020, 2, "R5");
        // R5: single bit-5 read then success
        run_op(2'd1, 17'h00444, 8'hC3, 17'h1FFFF, 8'h20, 1, 1'b1, 8'hC3, 0);
        chk(r_err == 1'b0 && r_rd == 8'hC3, "R5", "bit5 once tolerated", {r_err, r_rd}, 9'h0C3);

        // R6: maker codes 0x40 and 0xDA ignore bit 5
        run_op(2'd1, 17'h01234, 8'h11, 17'h1FFFF, 8'h40, 4, 1'b1, 8'h11, 0);
        chk(r_err == 1'b0, "R6", "0x40 ignores bit5", r_err, 0);
        check_reads_at(17'h01234, 5, "R6");
        run_op(2'd2, 17'h13333, 8'h00, 17'h1FF80, 8'hDA, 3, 1'b1, 8'h80, 0);
        chk(r_err == 1'b0, "R6", "0xDA ignores bit5", r_err, 0);
        check_reads_at(17'h13333, 4, "R6");

        // R7: timeout after POLL_MAX reads (with and without ignored bit 5)
        run_op(2'd1, 17'h1FFFF, 8'hFF, 17'h1FFFF, 8'h02, 1000, 1'b0, 8'hFF, 0);
        chk(r_err == 1'b1, "R7", "timeout error", r_err, 1);
        check_reads_at(17'h1FFFF, PM, "R7");
        check_poll_gap("R7");
        run_op(2'd2, 17'h00000, 8'h00, 17'h1FFFF, 8'h40, 1000, 1'b1, 8'h80, 0);
        chk(r_err == 1'b1, "R7", "timeout error erase", r_err, 1);
        check_reads_at(17'h00000, PM, "R7");

        // R8: identity read
        run_op(2'd3, 17'h1AAAA, 8'h00, 17'h1FFFF, 8'h00, 0, 1'b0, 8'hBF, 0);
        check_writes(2'd3, 17'h1AAAA, 8'h00, 17'h1FFFF, 8'h00, "R8");
        check_reads_at(17'h00001, 1, "R8");
        chk(r_err == 1'b0 && r_rd == 8'hBF, "R8", "identity byte", {r_err, r_rd}, 9'h0BF);

        // R9 R10: plain reads across both banks
        for (int k = 0; k < 8; k++) begin
            a = 17'($urandom); if (k < 2) a[16] = k[0];
            v = 8'($urandom);
            run_op(2'd0, a, 8'h00, 17'h1FFFF, 8'h00, 0, 1'b0, v, 0);
            chk(r_w == 0, "R9", "no writes on read", r_w, 0);
            check_reads_at(a, 1, "R9/R10");
            chk(r_err == 1'b0 && r_rd == v, "R9", "read byte", {r_err, r_rd}, {1'b0, v});
        end

        // R12: start while busy is ignored and not queued
        run_op(2'd1, 17'h0F0F0, 8'h3C, 17'h1FFFF, 8'h03, 2, 1'b0, 8'h3C, 1);
        check_writes(2'd1, 17'h0F0F0, 8'h3C, 17'h1FFFF, 8'h03, "R12");
        check_reads_at(17'h0F0F0, 3, "R12");
        wb = wn; rb = rn;
        repeat (40) @(negedge clk);
        chk(!busy && wn == wb && rn == rb, "R12", "no queued command", {busy, 8'(wn - wb), 8'(rn - rb)}, 0);

        // R11: strobe widths across the whole run
        chk(bad_stb == 0, "R11", "strobe width violations", bad_stb, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule